// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 binary operands and turns the result into a four-bit condition flag word for a coprocessor status path. Each operand arrives on a 64-bit bus with a one-bit type tag. A single-precision value sits in the low 32 bits of its bus. A double-precision value fills the whole bus. If both operands are single, the comparison is made in single precision. If the pair is mixed, the single operand is first widened exactly to double, denormals included, and the comparison is made in double precision.

A three-bit command field selects what the unit does. One bit marks the request as a compare. Without it, the request is consumed and produces nothing. A second bit chooses the variant that raises an invalid-operation exception when a NaN appears. A third bit inverts the sign of the second operand before the comparison. When either operand is a NaN, the result is unordered. The overflow flag is then set, and the carry flag follows an alternate-compare control input taken from the status register.

Requests enter through a valid/ready handshake and results leave through one. There is one result register. The upstream side is ready when that register is empty or is being drained in the same cycle, so a stall on the output stops intake. A result appears in the cycle after its request is accepted. It is held unchanged for as long as `out_ready` stays low. The invalid-operation indication travels with the result and is meaningful only while `out_valid` is high.

Top module: `fpcmp_flags`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. After reset `out_valid` is low. An accepted compare request gives `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, `out_flags` and `out_invalid` stay stable.
- R2: An accepted request with `in_cmd[2]` = 0 produces no result: on the next cycle `out_valid` is low.
- R3: The flag word `out_flags` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. For ordered operands, exactly one flag is set: N when the first operand is less than the second, Z when the two are equal, and C when the first is greater.
- R4: Zeros of either sign compare equal. Comparing +0 with -0 sets only Z.
- R5: A type tag of 0 means single and 1 means double. If both operands are single, they are compared in single precision. Otherwise any single operand is widened exactly to double, and the comparison is made in double precision.
- R6: When `in_cmd[0]` = 1, the sign bit of the second operand is inverted before the comparison. This is bit 31 for a single operand and bit 63 for a double operand.
- R7: A NaN is an operand with an all-ones exponent and a nonzero fraction, whether quiet or signalling. If either operand is a NaN, V is set and N and Z are cleared.
- R8: On an unordered result, C equals `ac_mode`.
- R9: `out_invalid` is 1 only for an unordered result with `in_cmd[1]` = 1. It is 0 for every ordered result and for every result of the plain variant.
- R10: Infinities order beyond all finite values. Denormals of both formats are ordered by their exact value.
- R11: For a single operand, bits 63:32 of its bus have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_a | input | 64 | First operand (single in bits 31:0) |
| in_a_dbl | input | 1 | First operand type: 1 double, 0 single |
| in_b | input | 64 | Second operand (single in bits 31:0) |
| in_b_dbl | input | 1 | Second operand type: 1 double, 0 single |
| in_cmd | input | 3 | [2] compare, [1] raise on NaN, [0] negate second operand |
| ac_mode | input | 1 | Status control bit giving C on unordered results |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_flags | output | 4 | N, Z, C, V in bits 3..0 |
| out_invalid | output | 1 | Invalid-operation indication for this result |

## Verification
Two things can happen in the same cycle: the previous result is drained and the next request is accepted. The bench provokes this in two ways. It raises `out_ready` while a second request is already waiting behind a stalled result, and it streams requests back to back with the output always ready. In both cases each flag word is judged against the value computed from its own operands, so a result that is lost, repeated or taken from the wrong request shows up as a mismatch. A near-exhaustive sweep over a catalogue of signed zeros, denormals, infinities and quiet and signalling NaNs in both formats covers every compare variant and both `ac_mode` values. The expected flags come from real-number arithmetic in the bench.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int SP_BIAS = (1 << (SP_EXP - 1)) - 1;
  localparam int DP_BIAS = (1 << (DP_EXP - 1)) - 1;

  // command field bit positions
  localparam int CMD_W     = 3;
  localparam int CMD_CMP   = 2;
  localparam int CMD_RAISE = 1;
  localparam int CMD_NEG   = 0;

  // flag word, N in the top bit, V in the bottom bit
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cc_t;
endpackage

// File: rtl/fpcmp_nan.sv
module fpcmp_nan #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] x,
  output logic         is_nan
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  assign ex = x[W-2:FRAC_W];
  assign fr = x[FRAC_W-1:0];
  assign is_nan = (&ex) && (|fr);
endmodule

// File: rtl/fpcmp_widen.sv
// Exact single to double conversion; denormal singles become normal doubles.
module fpcmp_widen
  import fpcmp_pkg::*;
(
  input  logic [SP_W-1:0] s,
  output logic [DP_W-1:0] d
);
  localparam int LEAD_W = $clog2(SP_FRAC);
  localparam int PAD    = DP_FRAC - SP_FRAC;

  logic                sgn;
  logic [SP_EXP-1:0]   ex;
  logic [SP_FRAC-1:0]  fr;
  logic [LEAD_W-1:0]   lead;
  logic [5:0]          shamt;
  logic [DP_FRAC-1:0]  norm;
  logic [DP_EXP-1:0]   ex_d;
  logic [DP_FRAC-1:0]  fr_d;

  assign sgn = s[SP_W-1];
  assign ex  = s[SP_W-2:SP_FRAC];
  assign fr  = s[SP_FRAC-1:0];

  // position of the highest set fraction bit
  always_comb begin
    lead = '0;
    for (int i = 0; i < SP_FRAC; i++) begin
      if (fr[i]) lead = LEAD_W'(i);
    end
  end

  assign shamt = 6'(DP_FRAC) - 6'(lead);
  assign norm  = {{PAD{1'b0}}, fr} << shamt;

  always_comb begin
    if (&ex) begin
      ex_d = '1;
      fr_d = {fr, {PAD{1'b0}}};
    end else if (ex != '0) begin
      ex_d = DP_EXP'(ex) + DP_EXP'(DP_BIAS - SP_BIAS);
      fr_d = {fr, {PAD{1'b0}}};
    end else if (fr != '0) begin
      ex_d = DP_EXP'(lead) + DP_EXP'(DP_BIAS - SP_BIAS - SP_FRAC + 1);
      fr_d = norm;
    end else begin
      ex_d = '0;
      fr_d = '0;
    end
  end

  assign d = {sgn, ex_d, fr_d};
endmodule

// File: rtl/fpcmp_order.sv
// Ordered comparison of two sign-magnitude encodings (NaN handled elsewhere).
module fpcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         eq,
  output logic         gt
);
  logic         sa, sb;
  logic [W-2:0] ma, mb;
  logic         both_zero;

  assign sa = a[W-1];
  assign sb = b[W-1];
  assign ma = a[W-2:0];
  assign mb = b[W-2:0];
  assign both_zero = (ma == '0) && (mb == '0);

  always_comb begin
    eq = (a == b) || both_zero;
    if (both_zero)     lt = 1'b0;
    else if (sa != sb) lt = sa;
    else if (!sa)      lt = (ma < mb);
    else               lt = (mb < ma);
    gt = !lt && !eq;
  end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
  import fpcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DP_W-1:0]  in_a,
  input  logic             in_a_dbl,
  input  logic [DP_W-1:0]  in_b,
  input  logic             in_b_dbl,
  input  logic [CMD_W-1:0] in_cmd,
  input  logic             ac_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_flags,
  output logic             out_invalid
);
  localparam int NOPS = 2;

  // operand 0 is the first, operand 1 the second (possibly negated)
  logic [SP_W-1:0] op_s [NOPS];
  logic [DP_W-1:0] op_d [NOPS];
  logic [DP_W-1:0] op_w [NOPS];
  logic            op_dbl [NOPS];
  logic            nan_s [NOPS];
  logic            nan_d [NOPS];
  logic            op_nan [NOPS];

  logic neg;
  assign neg = in_cmd[CMD_NEG];

  assign op_s[0]   = in_a[SP_W-1:0];
  assign op_d[0]   = in_a;
  assign op_dbl[0] = in_a_dbl;
  assign op_s[1]   = {in_b[SP_W-1] ^ neg, in_b[SP_W-2:0]};
  assign op_d[1]   = {in_b[DP_W-1] ^ neg, in_b[DP_W-2:0]};
  assign op_dbl[1] = in_b_dbl;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic [DP_W-1:0] widened;
    fpcmp_nan #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_nan_s (
      .x(op_s[k]), .is_nan(nan_s[k]));
    fpcmp_nan #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_nan_d (
      .x(op_d[k]), .is_nan(nan_d[k]));
    fpcmp_widen u_widen (.s(op_s[k]), .d(widened));
    assign op_w[k]   = op_dbl[k] ? op_d[k] : widened;
    assign op_nan[k] = op_dbl[k] ? nan_d[k] : nan_s[k];
  end

  logic lt_s, eq_s, gt_s;
  logic lt_d, eq_d, gt_d;

  fpcmp_order #(.W(SP_W)) u_ord_s (
    .a(op_s[0]), .b(op_s[1]), .lt(lt_s), .eq(eq_s), .gt(gt_s));
  fpcmp_order #(.W(DP_W)) u_ord_d (
    .a(op_w[0]), .b(op_w[1]), .lt(lt_d), .eq(eq_d), .gt(gt_d));

  logic both_single, unordered;
  cc_t  cc_next;
  logic inv_next;

  assign both_single = !op_dbl[0] && !op_dbl[1];
  assign unordered   = op_nan[0] || op_nan[1];

  always_comb begin
    if (unordered) begin
      cc_next = '{n: 1'b0, z: 1'b0, c: ac_mode, v: 1'b1};
    end else if (both_single) begin
      cc_next = '{n: lt_s, z: eq_s, c: gt_s, v: 1'b0};
    end else begin
      cc_next = '{n: lt_d, z: eq_d, c: gt_d, v: 1'b0};
    end
    inv_next = unordered && in_cmd[CMD_RAISE];
  end

  // single result register with valid/ready on both sides
  logic accept;
  logic vld_q;
  cc_t  cc_q;
  logic inv_q;

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cc_q  <= '0;
      inv_q <= 1'b0;
    end else begin
      if (accept) begin
        vld_q <= in_cmd[CMD_CMP];
        if (in_cmd[CMD_CMP]) begin
          cc_q  <= cc_next;
          inv_q <= inv_next;
        end
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_flags   = cc_q;
  assign out_invalid = inv_q;
endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_cmd,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_flags,
  input logic       out_invalid
);
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_cmd[2] |=> out_valid); // R1

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flags) && $stable(out_invalid)); // R1

  AST_NO_RESULT_WITHOUT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_cmd[2] |=> !out_valid); // R2

  AST_ORDERED_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_flags[0] |-> $countones(out_flags[3:1]) == 1); // R3

  AST_UNORDERED_NZ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[0] |-> !out_flags[3] && !out_flags[2]); // R7

  AST_INVALID_ONLY_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_flags[0]); // R9
endmodule

bind fpcmp_flags fpcmp_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_cmd(in_cmd), .out_valid(out_valid), .out_ready(out_ready),
  .out_flags(out_flags), .out_invalid(out_invalid));

// File: tb/tb_fpcmp_flags.sv
module tb_fpcmp_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT = 25;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic        in_a_dbl = 1'b0;
  logic [63:0] in_b = '0;
  logic        in_b_dbl = 1'b0;
  logic [2:0]  in_cmd = '0;
  logic        ac_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_flags;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  fpcmp_flags dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_a_dbl(in_a_dbl), .in_b(in_b), .in_b_dbl(in_b_dbl),
    .in_cmd(in_cmd), .ac_mode(ac_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_flags(out_flags), .out_invalid(out_invalid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      report();
    end
  end

  task automatic check(string req, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  // operand catalogue: {is_double, bits}
  function automatic logic [64:0] pat(int i);
    case (i)
      0:  return {1'b0, 64'hDEADBEEF_00000000};
      1:  return {1'b0, 64'h12345678_80000000};
      2:  return {1'b0, 64'hFFFFFFFF_3F800000};
      3:  return {1'b0, 64'h00000000_BF800000};
      4:  return {1'b0, 64'hA5A5A5A5_3F800001};
      5:  return {1'b0, 64'h0F0F0F0F_7F800000};
      6:  return {1'b0, 64'h00000000_FF800000};
      7:  return {1'b0, 64'hCAFEF00D_00000001};
      8:  return {1'b0, 64'h00000000_00400000};
      9:  return {1'b0, 64'h11111111_7FC00000};
      10: return {1'b0, 64'h00000000_7F800001};
      11: return {1'b0, 64'h77777777_7F7FFFFF};
      12: return {1'b0, 64'h00000000_40000000};
      13: return {1'b1, 64'h0000000000000000};
      14: return {1'b1, 64'h8000000000000000};
      15: return {1'b1, 64'h3FF0000000000000};
      16: return {1'b1, 64'h3FF0000000000001};
      17: return {1'b1, 64'h3810000000000000};
      18: return {1'b1, 64'h36A0000000000000};
      19: return {1'b1, 64'h7FF0000000000000};
      20: return {1'b1, 64'hFFF8000000000000};
      21: return {1'b1, 64'h7FF0000000000001};
      22: return {1'b1, 64'h0000000000000001};
      23: return {1'b1, 64'hBFF0000000000000};
      default: return {1'b1, 64'h4000000000000000};
    endcase
  endfunction

  function automatic real pow2(int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic real sp_val(logic [31:0] s);
    real m;
    real r;
    if (s[30:23] == 8'hFF) return $bitstoreal(s[31] ? 64'hFFF0000000000000 : 64'h7FF0000000000000);
    if (s[30:23] == 8'h00) r = real'(s[22:0]) * pow2(-149);
    else begin
      m = 1.0 + real'(s[22:0]) / pow2(23);
      r = m * pow2(int'(s[30:23]) - 127);
    end
    return s[31] ? -r : r;
  endfunction

  function automatic bit is_nan(logic [63:0] x, logic dbl);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic real val(logic [63:0] x, logic dbl);
    return dbl ? $bitstoreal(x) : sp_val(x[31:0]);
  endfunction

  // expected {valid, N, Z, C, V, invalid}
  function automatic logic [5:0] expect_res(logic [63:0] a, logic ad, logic [63:0] b,
                                             logic bd, logic [2:0] cmd, logic ac);
    real va, vb;
    if (is_nan(a, ad) || is_nan(b, bd)) return {1'b1, 1'b0, 1'b0, ac, 1'b1, cmd[1]};
    va = val(a, ad);
    vb = val(b, bd);
    if (cmd[0]) vb = -vb;
    if (va < vb) return 6'b110000;
    if (va == vb) return 6'b101000;
    return 6'b100100;
  endfunction

  task automatic drive(logic [63:0] a, logic ad, logic [63:0] b, logic bd,
                       logic [2:0] cmd, logic ac);
    in_a = a; in_a_dbl = ad; in_b = b; in_b_dbl = bd; in_cmd = cmd; ac_mode = ac;
  endtask

  // one request with the output always ready; checked one cycle later
  task automatic one(string req, logic [63:0] a, logic ad, logic [63:0] b, logic bd,
                     logic [2:0] cmd, logic ac);
    @(negedge clk);
    drive(a, ad, b, bd, cmd, ac);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_flags, out_invalid}, expect_res(a, ad, b, bd, cmd, ac));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {out_valid, in_ready, 4'b0}, {1'b0, 1'b1, 4'b0});
    rst_n = 1'b1;

    // directed corner cases
    one("R4 +0 vs -0", 64'h0, 1'b0, 64'h80000000, 1'b0, 3'b100, 1'b0);
    one("R4 mixed zeros", 64'h8000000000000000, 1'b1, 64'h0, 1'b0, 3'b100, 1'b0);
    one("R10 R5 single denorm vs double", 64'h1, 1'b0, 64'h36A0000000000000, 1'b1, 3'b100, 1'b0);
    one("R11 upper bits ignored", 64'hFFFFFFFF_3F800000, 1'b0, 64'h00000000_3F800000, 1'b0, 3'b100, 1'b0);
    one("R6 negate single", 64'h3F800000, 1'b0, 64'hBF800000, 1'b0, 3'b101, 1'b0);
    one("R9 plain variant silent", 64'h7FC00000, 1'b0, 64'h0, 1'b0, 3'b100, 1'b1);
    one("R8 R9 raise variant", 64'h0, 1'b1, 64'h7F800001, 1'b0, 3'b110, 1'b1);

    // R2: request without the compare bit gives no result
    @(negedge clk);
    drive(64'h7FC00000, 1'b0, 64'h0, 1'b0, 3'b011, 1'b1);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 no compare", {out_valid, in_ready, 4'b0}, {1'b0, 1'b1, 4'b0});

    // R1: stall, second request waits, then drain and accept in one cycle
    out_ready = 1'b0;
    drive(64'h3F800000, 1'b0, 64'h40000000, 1'b0, 3'b100, 1'b0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(64'h40000000, 1'b0, 64'h3F800000, 1'b0, 3'b100, 1'b0);
    check("R1 stalled result", {out_valid, out_flags, out_invalid}, 6'b110000);
    check("R1 ready low on stall", {5'b0, in_ready}, 6'b0);
    @(posedge clk);
    @(negedge clk);
    check("R1 held while stalled", {out_valid, out_flags, out_invalid}, 6'b110000);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 drain and accept", {out_valid, out_flags, out_invalid}, 6'b100100);
    @(posedge clk);
    @(negedge clk);
    check("R1 empty after drain", {out_valid, 5'b0}, 6'b0);

    // R1: back-to-back streaming
    drive(64'h3FF0000000000000, 1'b1, 64'h3F800000, 1'b0, 3'b100, 1'b0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(64'hBFF0000000000000, 1'b1, 64'h0, 1'b1, 3'b100, 1'b0);
    check("R1 stream first", {out_valid, out_flags, out_invalid}, 6'b101000);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream second", {out_valid, out_flags, out_invalid}, 6'b110000);

    // sweep over all catalogue pairs and variants
    for (int i = 0; i < NPAT; i++) begin
      for (int j = 0; j < NPAT; j++) begin
        for (int v = 0; v < 8; v++) begin
          logic [64:0] pa, pb;
          string tag;
          pa = pat(i);
          pb = pat(j);
          if (is_nan(pa[63:0], pa[64]) || is_nan(pb[63:0], pb[64])) tag = "R7 R8 R9 unordered";
          else if (v[0]) tag = "R6 negated";
          else if (pa[64] != pb[64]) tag = "R5 R10 mixed";
          else tag = "R3 R10 ordered";
          one(tag, pa[63:0], pa[64], pb[63:0], pb[64], {1'b1, v[1], v[0]}, v[2]);
        end
      end
    end

    done = 1;
    report();
  end
endmodule